// File: doc/BRIEF.md
# I2C Downstream Bus Recovery Sequencer

This block sits between a channel-selection controller and a downstream I2C bus. When a controller asks to take over the bus, the block is started with a single-cycle pulse. If recovery is turned on, it drives a fixed clean-up pattern onto the downstream wires before the switch may happen. It first toggles SCL nine times with SDA left floating, so that any target stuck in the middle of a byte can finish shifting it out. It then gives one more pulse with SDA high, which the target reads as a not-acknowledge. Last, it issues a STOP condition.

Only after that last step does the block raise a one-cycle switch-permit pulse, together with a one-cycle done pulse for the upstream side that asked. If recovery is off, the permit comes at once and the bus lines are never touched.

The block only produces open-drain drive enables: a 1 on an enable pulls the wire low, and a 0 releases it to its pull-up. The length of each SCL half-period is set in system clocks through `halfPeriod`. A value of 250 at a 50 MHz system clock gives about 100 kHz.

Top module: `busRecoverySeq`

## Requirements
- R1: While reset is held, and whenever the block is idle with no pulse due, all five outputs (`sclDriveLow`, `sdaDriveLow`, `busy`, `switchPermit`, `donePulse`) are 0.
- R2: A start pulse with `recoverEn`=0 makes `switchPermit` 1 for exactly the one cycle after the start is sampled. `busy`, `donePulse` and both drive enables stay 0.
- R3: A start pulse with `recoverEn`=1 raises `busy` in the cycle after the start is sampled. `busy` then stays 1 for exactly 23·H cycles, where H is the effective half-period.
- R4: The first 18 half-periods of the run form nine SCL pulses. Each pulse is SCL driven low for H cycles, then SCL released for H cycles. `sdaDriveLow` stays 0 throughout.
- R5: Half-periods 19 and 20 form a tenth SCL pulse (low, then released) with SDA released: the not-acknowledge.
- R6: The STOP takes three half-periods. In half 21 both SCL and SDA are driven low. In half 22 SCL is released while SDA stays low. In half 23 both are released, so SDA rises while SCL is high.
- R7: In the first cycle after `busy` falls, `switchPermit` and `donePulse` are both 1 for exactly one cycle. `switchPermit` is never 1 while `busy` is 1.
- R8: A start pulse that arrives while `busy` is 1 is ignored: the run in progress keeps its timing and ends with a single permit/done pair.
- R9: `halfPeriod` is captured when a run starts. Later changes do not affect that run. A captured value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to switch channels |
| recoverEn | input | 1 | 1 = run the recovery pattern before permitting the switch |
| halfPeriod | input | DIV_W (16) | SCL half-period in system clocks, captured at start |
| sclDriveLow | output | 1 | 1 = pull downstream SCL low |
| sdaDriveLow | output | 1 | 1 = pull downstream SDA low |
| busy | output | 1 | Recovery pattern in progress |
| switchPermit | output | 1 | One-cycle pulse: the channel may be switched now |
| donePulse | output | 1 | One-cycle pulse to the requester: recovery finished |

## Verification
The properties assume that `startPulse` is a single-cycle strobe. They also assume `recoverEn` is steady around the cycle in which a start is sampled, since the line-order checks only hold for edges that this block itself creates. The stimulus drives every input on the falling clock edge, keeps each start pulse one cycle wide, and sends extra starts only while `busy` is high. It changes `halfPeriod` only after a run has latched it, including a value of 0 and a value that is changed mid-run.

// File: rtl/busRecoveryPkg.sv
package busRecoveryPkg;

  // Strobes from the sequence control to the datapath.
  typedef struct packed {
    logic load;   // capture divisor, clear counters
    logic run;    // pattern is being driven
  } seqStrobe_t;

  // Which part of the pattern the current half-period belongs to.
  typedef enum logic [1:0] {
    PH_TOGGLE    = 2'd0,  // clock pulses, including the not-acknowledge
    PH_STOP_HOLD = 2'd1,  // SCL and SDA both low
    PH_STOP_RISE = 2'd2,  // SCL released, SDA low
    PH_STOP_FREE = 2'd3   // both released
  } seqPhase_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlState_e;

endpackage

// File: rtl/recoveryDatapath.sv
module recoveryDatapath
  import busRecoveryPkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int NUM_PULSES = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [DIV_W-1:0] halfPeriod,
  output logic             halfEnd,
  output logic             lastHalf,
  output logic             sclDriveLow,
  output logic             sdaDriveLow
);

  // Clock pulses plus the not-acknowledge pulse, two halves each.
  localparam int TOGGLE_HALVES = 2 * (NUM_PULSES + 1);
  // Three more halves for the STOP.
  localparam int TOTAL_HALVES  = TOGGLE_HALVES + 3;
  localparam int IDX_W         = $clog2(TOTAL_HALVES + 1);

  logic [DIV_W-1:0] divLatch;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] halfIdx;
  seqPhase_e        phase;

  // Divisor capture; a zero request becomes the shortest legal half.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divLatch <= DIV_W'(1);
    end else if (strobe.load) begin
      divLatch <= (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
    end
  end

  assign halfEnd  = strobe.run && (divCnt == divLatch - DIV_W'(1));
  assign lastHalf = (halfIdx == IDX_W'(TOTAL_HALVES - 1));

  // Clock-within-half counter and half-period index.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      halfIdx <= '0;
    end else if (strobe.load) begin
      divCnt  <= '0;
      halfIdx <= '0;
    end else if (strobe.run) begin
      if (halfEnd) begin
        divCnt <= '0;
        if (!lastHalf) begin
          halfIdx <= halfIdx + IDX_W'(1);
        end
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  // Map the index onto a phase of the pattern.
  always_comb begin
    if (halfIdx < IDX_W'(TOGGLE_HALVES)) begin
      phase = PH_TOGGLE;
    end else if (halfIdx == IDX_W'(TOGGLE_HALVES)) begin
      phase = PH_STOP_HOLD;
    end else if (halfIdx == IDX_W'(TOGGLE_HALVES + 1)) begin
      phase = PH_STOP_RISE;
    end else begin
      phase = PH_STOP_FREE;
    end
  end

  // Open-drain enables; even halves of the toggle phase pull SCL low.
  always_comb begin
    sclDriveLow = 1'b0;
    sdaDriveLow = 1'b0;
    if (strobe.run) begin
      unique case (phase)
        PH_TOGGLE:    sclDriveLow = ~halfIdx[0];
        PH_STOP_HOLD: begin
          sclDriveLow = 1'b1;
          sdaDriveLow = 1'b1;
        end
        PH_STOP_RISE: sdaDriveLow = 1'b1;
        PH_STOP_FREE: ;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/recoveryCtrl.sv
module recoveryCtrl
  import busRecoveryPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       recoverEn,
  input  logic       halfEnd,
  input  logic       lastHalf,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       switchPermit,
  output logic       donePulse
);

  ctrlState_e state;
  logic       permitR;
  logic       doneR;
  logic       acceptStart;

  // A start is only accepted in idle; in run it is dropped.
  assign acceptStart = (state == ST_IDLE) && startPulse;

  assign strobe.load = acceptStart && recoverEn;
  assign strobe.run  = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      permitR <= 1'b0;
      doneR   <= 1'b0;
    end else begin
      permitR <= 1'b0;
      doneR   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (acceptStart) begin
            if (recoverEn) begin
              state <= ST_RUN;
            end else begin
              permitR <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (halfEnd && lastHalf) begin
            state   <= ST_IDLE;
            permitR <= 1'b1;
            doneR   <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state == ST_RUN);
  assign switchPermit = permitR;
  assign donePulse    = doneR;

endmodule

// File: rtl/busRecoverySeq.sv
module busRecoverySeq
  import busRecoveryPkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int NUM_PULSES = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             recoverEn,
  input  logic [DIV_W-1:0] halfPeriod,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             busy,
  output logic             switchPermit,
  output logic             donePulse
);

  seqStrobe_t strobe;
  logic       halfEnd;
  logic       lastHalf;

  recoveryCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startPulse   (startPulse),
    .recoverEn    (recoverEn),
    .halfEnd      (halfEnd),
    .lastHalf     (lastHalf),
    .strobe       (strobe),
    .busy         (busy),
    .switchPermit (switchPermit),
    .donePulse    (donePulse)
  );

  recoveryDatapath #(
    .DIV_W      (DIV_W),
    .NUM_PULSES (NUM_PULSES)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .halfPeriod  (halfPeriod),
    .halfEnd     (halfEnd),
    .lastHalf    (lastHalf),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow)
  );

endmodule

// File: rtl/recoverySeqChecker.sv
module recoverySeqChecker (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic recoverEn,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic busy,
  input logic switchPermit,
  input logic donePulse
);

  // R1 / R2: lines are untouched unless a run is in progress.
  p_lines_free_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow));

  // R7: no permit while the pattern is still on the bus.
  p_no_permit_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !switchPermit);

  // R7: done comes only at the end of a run, together with the permit.
  p_done_after_run_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (switchPermit && $past(busy)));

  // R2: a permit is caused either by a start or by the end of a run.
  p_permit_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    switchPermit |-> ($past(startPulse) || $past(busy)));

  // R6: SDA is released (rises) only while SCL is released.
  p_stop_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDriveLow) |-> !sclDriveLow);

  // R6: SDA is pulled low only while SCL is low, so no START is formed.
  p_no_false_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> sclDriveLow);

  // R7: permit and done are single-cycle pulses.
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    switchPermit |=> !switchPermit);

  // R8: a start during a run does not end it on the next cycle.
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startPulse && $past(busy)) |=> !(switchPermit && !donePulse));

endmodule

bind busRecoverySeq recoverySeqChecker i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .startPulse   (startPulse),
  .recoverEn    (recoverEn),
  .sclDriveLow  (sclDriveLow),
  .sdaDriveLow  (sdaDriveLow),
  .busy         (busy),
  .switchPermit (switchPermit),
  .donePulse    (donePulse)
);

// File: tb/test_busRecoverySeq.sv
module test_busRecoverySeq;

  localparam int DIV_W   = 16;
  localparam int HALVES  = 23;

  typedef struct {
    logic [4:0] vec;   // {scl, sda, busy, permit, done}
    string      tag;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN;
  logic             startPulse;
  logic             recoverEn;
  logic [DIV_W-1:0] halfPeriod;
  logic             sclDriveLow;
  logic             sdaDriveLow;
  logic             busy;
  logic             switchPermit;
  logic             donePulse;

  expItem_t expQ[$];
  int       checkCount = 0;
  int       failCount  = 0;
  bit       monOn      = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  busRecoverySeq #(.DIV_W(DIV_W), .NUM_PULSES(9)) i_busRecoverySeq (
    .clk          (clk),
    .rstN         (rstN),
    .startPulse   (startPulse),
    .recoverEn    (recoverEn),
    .halfPeriod   (halfPeriod),
    .sclDriveLow  (sclDriveLow),
    .sdaDriveLow  (sdaDriveLow),
    .busy         (busy),
    .switchPermit (switchPermit),
    .donePulse    (donePulse)
  );

  function automatic logic [4:0] outVec();
    return {sclDriveLow, sdaDriveLow, busy, switchPermit, donePulse};
  endfunction

  task automatic compare(input logic [4:0] exp, input string tag);
    checkCount++;
    if (outVec() !== exp) begin
      failCount++;
      $display("FAIL %s at %0t: got {scl,sda,busy,permit,done}=%b expected %b",
               tag, $time, outVec(), exp);
    end
  endtask

  // Expected line pattern for half h, written from R4, R5, R6.
  function automatic logic [1:0] lineExp(input int h);
    if (h < 18) return {(h % 2 == 0), 1'b0};        // R4
    if (h < 20) return {(h % 2 == 0), 1'b0};        // R5
    if (h == 20) return 2'b11;                      // R6 hold
    if (h == 21) return 2'b01;                      // R6 SCL up
    return 2'b00;                                   // R6 SDA up
  endfunction

  function automatic string halfTag(input int h);
    if (h < 18) return "R3 R4";
    if (h < 20) return "R3 R5";
    return "R3 R6";
  endfunction

  task automatic pulseStart();
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Driver: push expected cycles, then apply the start.
  // extraStartAt > 0 sends a second start that many cycles into the run.
  // changeHp >= 0 changes halfPeriod after the start has been taken.
  task automatic runSeq(input bit en, input int hp, input int extraStartAt,
                        input int changeHp, input string ctx);
    int eff;
    eff = (hp == 0) ? 1 : hp;
    if (!en) begin
      expQ.push_back('{5'b00010, {ctx, " R2"}});
    end else begin
      for (int h = 0; h < HALVES; h++) begin
        for (int c = 0; c < eff; c++) begin
          expQ.push_back('{{lineExp(h), 3'b100}, {ctx, " ", halfTag(h)}});
        end
      end
      expQ.push_back('{5'b00011, {ctx, " R7"}});
    end
    recoverEn  = en;
    halfPeriod = DIV_W'(hp);
    pulseStart();
    if (changeHp >= 0) halfPeriod = DIV_W'(changeHp);
    if (extraStartAt > 0) begin
      for (int i = 1; i < extraStartAt; i++) @(negedge clk);
      recoverEn = 1'b1;
      pulseStart();
    end
    waitDrain();
  endtask

  // Monitor: pop one expected item per cycle; idle is expected otherwise.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (monOn) begin
        if (expQ.size() != 0) begin
          expItem_t it;
          it = expQ.pop_front();
          compare(it.vec, it.tag);
        end else begin
          compare(5'b00000, "R1 idle");
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    failCount++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end

  initial begin
    rstN       = 1'b0;
    startPulse = 1'b0;
    recoverEn  = 1'b0;
    halfPeriod = DIV_W'(3);
    repeat (3) @(negedge clk);
    compare(5'b00000, "R1 in reset");
    // a start during reset must have no effect
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    compare(5'b00000, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;
    repeat (3) @(negedge clk);

    runSeq(1'b0, 3, 0, -1, "R2 disabled");
    runSeq(1'b1, 1, 0, -1, "H1");
    runSeq(1'b1, 3, 0, -1, "H3");
    runSeq(1'b0, 5, 0, -1, "R2 again");
    runSeq(1'b1, 2, 7, -1, "R8 extra start");
    runSeq(1'b1, 2, 45, -1, "R8 late start");
    runSeq(1'b1, 4, 0, 9, "R9 change");
    runSeq(1'b1, 0, 0, -1, "R9 zero");
    runSeq(1'b1, 250, 0, -1, "100k");
    // back-to-back: start right after the permit cycle
    runSeq(1'b1, 2, 0, -1, "B2B");
    runSeq(1'b0, 2, 0, -1, "R2 after run");
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
    $finish;
  end

endmodule